// File: doc/BRIEF.md
# Selectable Test Pattern Generator and Verifier

This block feeds a storage test with 128-bit write words and checks the 128-bit words that come back on a later read against the same sequence. A start pulse latches a pattern kind and a start sector address. From then on, the block steps through the sequence by one word in each cycle in which the write side takes a word or the read side offers one. There are five pattern kinds. Two are derived from the running byte address, two are constant, and one comes from a linear feedback shift register whose seed is taken from the start address. Because of that seed, a write pass and a later read pass over the same region produce identical words.

The block keeps a running count of the bytes moved since the last start. The read side compares every offered word with the expected word. On the first difference it records three values: the byte address of the failing word, the expected word and the word received. It also raises a verify-fail flag that stays set until the next start. That flag is separate from any error reported by the storage device. All recorded values are presented on plain output ports.

Top module: `testpat_unit`

## Requirements
- R1: After reset, byteCount is 0, verifyFail is 0, and failAddr, failExp and failRead are all zero.
- R2: A cycle with start high latches patSel and startAddr. It also clears byteCount, verifyFail, failAddr, failExp and failRead. In that same cycle genEn and chkEn have no effect.
- R3: Pattern code 000 (increment) gives a word made of the 64-bit running byte address placed in both 64-bit halves. The running byte address is startAddr*512 + byteCount.
- R4: Pattern code 001 (decrement) gives the bitwise complement of the increment word for the same running byte address.
- R5: Code 010 gives all zeros and code 011 gives all ones. The unused codes 101, 110 and 111 also give all zeros.
- R6: Pattern code 100 uses a 32-bit shift register. Its seed is {startAddr[30:0], 1}. It advances once per word: it shifts left and the new bit 0 is the XOR of bits 31, 21, 1 and 0. The output word is the register value repeated in all four 32-bit lanes.
- R7: byteCount rises by 16 in every cycle with genEn or chkEn high. The sequence advances one word in that same cycle. With neither input high, byteCount and genData hold.
- R8: When chkEn is high, chkData differs from genData, and verifyFail is 0, the block records three values: the running byte address in failAddr (57 bits), genData in failExp, and chkData in failRead. It also sets verifyFail.
- R9: verifyFail stays set and the recorded values stay unchanged through any later mismatch, until the next start.
- R10: A checked word equal to genData leaves verifyFail at 0.
- R11: A change of patSel while no start is applied does not alter the pattern of the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new test |
| patSel | input | 3 | Pattern kind, latched on start |
| startAddr | input | 48 | Start sector address (512-byte sectors), latched on start |
| genEn | input | 1 | Write side takes genData this cycle |
| genData | output | 128 | Current expected/generated word |
| chkEn | input | 1 | Read side offers chkData this cycle |
| chkData | input | 128 | Word read back |
| byteCount | output | 57 | Bytes moved since start |
| verifyFail | output | 1 | Sticky mismatch flag |
| failAddr | output | 57 | Byte address of the first mismatch |
| failExp | output | 128 | Expected word at the first mismatch |
| failRead | output | 128 | Received word at the first mismatch |

## Verification
The hardest situation to reach is a second mismatch that arrives after the first has already been recorded, in the middle of a pseudo-random sequence. At that point the recorded values must stay put while the count and the sequence keep advancing. The stimulus starts a shift-register test, feeds one correct word, and then corrupts two consecutive read words in different bits. It then compares the recorded address and both recorded words with values worked out from the seed. A later start has to clear all of them.

// File: rtl/testpat_pkg.sv
package testpat_pkg;

  localparam int LANE_W = 32;

  typedef enum logic [2:0] {
    PAT_INC  = 3'b000,
    PAT_DEC  = 3'b001,
    PAT_ZERO = 3'b010,
    PAT_ONES = 3'b011,
    PAT_LFSR = 3'b100
  } patKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic capture;
  } dpCtl_t;

  // maximal-length 32-bit feedback, taps 32,22,2,1
  function automatic logic [LANE_W-1:0] lfsrNext(input logic [LANE_W-1:0] s);
    return {s[LANE_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/testpat_ctrl.sv
module testpat_ctrl
  import testpat_pkg::*;
#(
  parameter int CNT_W      = 57,
  parameter int STEP_BYTES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             genEn,
  input  logic             chkEn,
  input  logic             mismatch,
  output dpCtl_t           ctl,
  output logic [CNT_W-1:0] byteCount,
  output logic             verifyFail
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_BYTES);

  logic moving;
  assign moving = genEn || chkEn;

  always_comb begin
    ctl.load    = start;
    ctl.step    = !start && moving;
    ctl.capture = !start && chkEn && mismatch && !verifyFail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount  <= '0;
      verifyFail <= 1'b0;
    end else if (start) begin
      byteCount  <= '0;
      verifyFail <= 1'b0;
    end else begin
      if (moving)      byteCount  <= byteCount + STEP;
      if (ctl.capture) verifyFail <= 1'b1;
    end
  end

  // R7: counter advances one word of bytes per accepted word
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (moving && !start) |=> (byteCount == $past(byteCount) + STEP));

  // R7: counter holds when idle
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!moving && !start) |=> $stable(byteCount));

  // R2: start clears count and flag
  a_r2_start_clear: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (byteCount == '0) && !verifyFail);

  // R9: flag is sticky until start
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (verifyFail && !start) |=> verifyFail);

endmodule

// File: rtl/testpat_dp.sv
module testpat_dp
  import testpat_pkg::*;
#(
  parameter int DATA_W     = 128,
  parameter int ADDR_W     = 48,
  parameter int SECT_SHIFT = 9,
  parameter int CNT_W      = ADDR_W + SECT_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [2:0]        patSel,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] chkData,
  output logic [DATA_W-1:0] genData,
  output logic              mismatch,
  output logic [CNT_W-1:0]  failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failRead
);

  localparam int REPS  = DATA_W / 64;
  localparam int LANES = DATA_W / LANE_W;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);

  logic [2:0]        selQ;
  logic [CNT_W-1:0]  curAddr;
  logic [LANE_W-1:0] lfsr;
  logic [63:0]       addr64;
  logic [DATA_W-1:0] incWord;
  logic [DATA_W-1:0] lfsrWord;

  assign addr64 = 64'(curAddr);

  for (genvar i = 0; i < REPS; i++) begin : g_rep
    assign incWord[i*64 +: 64] = addr64;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lfsrWord[j*LANE_W +: LANE_W] = lfsr;
  end

  always_comb begin
    case (selQ)
      PAT_INC:  genData = incWord;
      PAT_DEC:  genData = ~incWord;
      PAT_ZERO: genData = '0;
      PAT_ONES: genData = '1;
      PAT_LFSR: genData = lfsrWord;
      default:  genData = '0;
    endcase
  end

  assign mismatch = (chkData != genData);

  // sequence state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= PAT_INC;
      curAddr <= '0;
      lfsr    <= LANE_W'(1);
    end else if (ctl.load) begin
      selQ    <= patSel;
      curAddr <= {startAddr, {SECT_SHIFT{1'b0}}};
      lfsr    <= {startAddr[LANE_W-2:0], 1'b1};
    end else if (ctl.step) begin
      curAddr <= curAddr + STEP;
      lfsr    <= lfsrNext(lfsr);
    end
  end

  // first-failure capture
  always_ff @(posedge clk) begin
    if (!rstN || ctl.load) begin
      failAddr <= '0;
      failExp  <= '0;
      failRead <= '0;
    end else if (ctl.capture) begin
      failAddr <= curAddr;
      failExp  <= genData;
      failRead <= chkData;
    end
  end

  // R6: shift register never locks up at zero
  a_r6_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  // R11: pattern kind only changes on a start
  a_r11_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(selQ));

  // R7: sequence holds when no word moves
  a_r7_seq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(genData));

endmodule

// File: rtl/testpat_unit.sv
module testpat_unit
  import testpat_pkg::*;
#(
  parameter int DATA_W     = 128,
  parameter int ADDR_W     = 48,
  parameter int SECT_SHIFT = 9,
  localparam int CNT_W     = ADDR_W + SECT_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        patSel,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              genEn,
  output logic [DATA_W-1:0] genData,
  input  logic              chkEn,
  input  logic [DATA_W-1:0] chkData,
  output logic [CNT_W-1:0]  byteCount,
  output logic              verifyFail,
  output logic [CNT_W-1:0]  failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failRead
);

  dpCtl_t ctl;
  logic   mismatch;

  testpat_ctrl #(
    .CNT_W      (CNT_W),
    .STEP_BYTES (DATA_W / 8)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .genEn      (genEn),
    .chkEn      (chkEn),
    .mismatch   (mismatch),
    .ctl        (ctl),
    .byteCount  (byteCount),
    .verifyFail (verifyFail)
  );

  testpat_dp #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SECT_SHIFT (SECT_SHIFT),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .patSel    (patSel),
    .startAddr (startAddr),
    .chkData   (chkData),
    .genData   (genData),
    .mismatch  (mismatch),
    .failAddr  (failAddr),
    .failExp   (failExp),
    .failRead  (failRead)
  );

  // R8: a newly raised flag comes with differing recorded words
  a_r8_capture_differs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(verifyFail) |-> (failExp != failRead));

  // R9: recorded values hold while flagged
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    (verifyFail && !start) |=> ($stable(failAddr) && $stable(failExp) && $stable(failRead)));

  // R10: a matching checked word never raises the flag
  a_r10_match_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!verifyFail && chkEn && !start && (chkData == genData)) |=> !verifyFail);

endmodule

// File: tb/testpat_unit_test.sv
module testpat_unit_test;

  localparam int NV = 8;
  localparam logic [2:0]  V_SEL  [NV] = '{3'b000, 3'b000, 3'b001, 3'b010,
                                          3'b011, 3'b100, 3'b100, 3'b110};
  localparam logic [47:0] V_ADDR [NV] = '{48'h0, 48'h0000_1234_5678, 48'h5, 48'h7,
                                          48'h9, 48'h0, 48'hABCD_EF01, 48'h3};
  localparam int          V_LEN  [NV] = '{4, 3, 3, 2, 2, 5, 4, 2};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   patSel = 3'b000;
  logic [47:0]  startAddr = '0;
  logic         genEn = 1'b0;
  logic         chkEn = 1'b0;
  logic [127:0] chkData = '0;
  logic [127:0] genData;
  logic [56:0]  byteCount;
  logic         verifyFail;
  logic [56:0]  failAddr;
  logic [127:0] failExp;
  logic [127:0] failRead;

  int nChecks = 0;
  int nFail   = 0;

  // bench model of the sequence
  logic [2:0]  mSel;
  logic [56:0] mAddr;
  logic [31:0] mLfsr;

  always #5 clk = ~clk;

  testpat_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .patSel(patSel), .startAddr(startAddr),
    .genEn(genEn), .genData(genData), .chkEn(chkEn), .chkData(chkData),
    .byteCount(byteCount), .verifyFail(verifyFail), .failAddr(failAddr),
    .failExp(failExp), .failRead(failRead)
  );

  function automatic logic [127:0] modelWord();
    logic [63:0] a;
    a = 64'(mAddr);
    case (mSel)
      3'b000:  return {a, a};
      3'b001:  return ~{a, a};
      3'b011:  return '1;
      3'b100:  return {mLfsr, mLfsr, mLfsr, mLfsr};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelAdvance();
    mAddr = mAddr + 57'd16;
    mLfsr = {mLfsr[30:0], mLfsr[31] ^ mLfsr[21] ^ mLfsr[1] ^ mLfsr[0]};
  endtask

  // called at a negedge, returns at the negedge after the start cycle
  task automatic doStart(input logic [2:0] sel, input logic [47:0] addr);
    start = 1'b1; patSel = sel; startAddr = addr;
    @(negedge clk);
    start = 1'b0;
    mSel = sel; mAddr = {addr, 9'b0}; mLfsr = {addr[30:0], 1'b1};
  endtask

  task automatic genWord(input string tag);
    check(tag, genData, modelWord());
    genEn = 1'b1;
    @(negedge clk);
    genEn = 1'b0;
    modelAdvance();
  endtask

  task automatic chkWord(input logic [127:0] flip);
    chkData = modelWord() ^ flip;
    chkEn = 1'b1;
    @(negedge clk);
    chkEn = 1'b0;
    modelAdvance();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [127:0] expW1;
    logic [56:0]  expA1;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 byteCount", 128'(byteCount), '0);
    check("R1 verifyFail", 128'(verifyFail), '0);
    check("R1 failAddr", 128'(failAddr), '0);
    check("R1 failExp", failExp, '0);
    check("R1 failRead", failRead, '0);

    // table of pattern vectors: R3 R4 R5 R6 R7 R2
    for (int v = 0; v < NV; v++) begin
      doStart(V_SEL[v], V_ADDR[v]);
      check("R2 count cleared", 128'(byteCount), '0);
      for (int w = 0; w < V_LEN[v]; w++) begin
        case (V_SEL[v])
          3'b000:  genWord("R3 increment word");
          3'b001:  genWord("R4 decrement word");
          3'b100:  genWord("R6 lfsr word");
          default: genWord("R5 constant word");
        endcase
      end
      check("R7 byte count", 128'(byteCount), 128'(V_LEN[v] * 16));
    end

    // R7 idle hold
    held = genData;
    repeat (3) @(negedge clk);
    check("R7 idle count", 128'(byteCount), 128'(V_LEN[NV-1] * 16));
    check("R7 idle data", genData, held);

    // R11 patSel change without start is ignored
    doStart(3'b000, 48'h2);
    genWord("R11 before change");
    patSel = 3'b011;
    @(negedge clk);
    genWord("R11 after change");
    check("R11 sequence kept", genData, modelWord());

    // R10 matching words keep the flag low
    doStart(3'b000, 48'h40);
    for (int w = 0; w < 3; w++) chkWord('0);
    check("R10 no fail on match", 128'(verifyFail), '0);

    // R8 first mismatch, R9 second mismatch
    doStart(3'b100, 48'h77);
    chkWord('0);
    check("R10 good first word", 128'(verifyFail), '0);
    expW1 = modelWord();
    expA1 = mAddr;
    chkWord(128'h1);
    check("R8 flag set", 128'(verifyFail), 128'(1));
    check("R8 fail address", 128'(failAddr), 128'(expA1));
    check("R8 fail address value", 128'(expA1), 128'h0000_EE10);
    check("R8 expected word", failExp, expW1);
    check("R8 read word", failRead, expW1 ^ 128'h1);
    chkWord({1'b1, 127'b0});
    check("R9 flag sticky", 128'(verifyFail), 128'(1));
    check("R9 address held", 128'(failAddr), 128'(expA1));
    check("R9 expected held", failExp, expW1);
    check("R9 read held", failRead, expW1 ^ 128'h1);
    check("R7 count through mismatch", 128'(byteCount), 128'd48);

    // R2 start clears capture; enables ignored in the start cycle
    start = 1'b1; patSel = 3'b000; startAddr = 48'h1; genEn = 1'b1;
    @(negedge clk);
    start = 1'b0; genEn = 1'b0;
    mSel = 3'b000; mAddr = {48'h1, 9'b0}; mLfsr = {31'h1, 1'b1};
    check("R2 flag cleared", 128'(verifyFail), '0);
    check("R2 address cleared", 128'(failAddr), '0);
    check("R2 expected cleared", failExp, '0);
    check("R2 read cleared", failRead, '0);
    check("R2 enable ignored in start cycle", 128'(byteCount), '0);
    check("R3 first word after start", genData, modelWord());

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule